// File: doc/BRIEF.md
# SPI Master Shift Engine with DMA Request Pulses

This block is a 4-wire SPI master built so that a DMA engine can keep it busy without processor help. A character of 2 to 16 bits moves out on MOSI while another moves in on MISO during the same transfer, MSB first. SCLK idles low. MOSI changes after each falling edge, and MISO is sampled on each rising edge. Each SCLK phase lasts a programmable number of system clocks.

A one-entry transmit buffer sits in front of the shift register. A write to the transmit data port goes straight into the shift register if the shifter is idle, and into the buffer if a character is already shifting. The buffered word follows with no gap, and chip select stays low between the two characters. Every time a word enters the shift register, from either place, a single-cycle transmit request pulses. Every time a finished character lands in the receive buffer, a single-cycle receive request pulses. One extra transmit request fires when the SPI enable and the request enable become 1 together, so that the DMA engine supplies the first word. Requests are suppressed while request enable is 0. Sticky flags record writes dropped against a full transmit buffer and received characters that replaced an unread one.

Top module: `spi_dma_master`

## Requirements
- R1: After synchronous reset, cs_n is 1, sclk, mosi, tx_req, rx_req, rx_valid, tx_ovr and rx_ovr are 0, and rx_rdata is 0.
- R2: The character length is taken from char_len when a word enters the shift register. Values below 2 count as 2 and values above 16 count as 16, so char_len = 0 moves a 2-bit character.
- R3: A character of N bits goes out as tx_wdata[N-1:0] MSB first, with sclk idling low. MOSI changes after the falling edges, and MISO is sampled on the rising edges. The received character appears right-aligned in rx_rdata with the upper bits 0. mosi is 0 while cs_n is 1.
- R4: The high phase and the low phase of sclk each last clk_half system clock cycles, and clk_half = 0 counts as 1.
- R5: tx_req pulses for one cycle each time a word enters the shift register, whether directly from a write or from the transmit buffer.
- R6: tx_req pulses once when spi_en and dma_req_en become 1 together, even if no data has been written.
- R7: rx_req pulses for one cycle each time a received character is copied into the receive buffer. rx_valid is 1 from that copy until an rx_rd pulse.
- R8: Neither tx_req nor rx_req rises in the cycle after one in which dma_req_en is 0. The transfers themselves still run.
- R9: cs_n is 0 for the whole of each character. It stays 0 between back-to-back characters, and it returns to 1 once the shift register and the transmit buffer are both empty.
- R10: A write while the transmit buffer is full is dropped and sets tx_ovr, which holds until reset.
- R11: A character that arrives while rx_valid is 1 and no rx_rd is present replaces the buffer contents and sets rx_ovr, which holds until reset.
- R12: While spi_en is 0, writes are ignored, any character in flight is abandoned, the transmit buffer empties and cs_n is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_en | input | 1 | Global enable for the shift engine |
| dma_req_en | input | 1 | Enables the tx_req and rx_req pulses |
| char_len | input | 5 | Character length in bits (clamped to 2..16) |
| clk_half | input | DIV_W | System clocks per SCLK phase (0 treated as 1) |
| tx_wr | input | 1 | Write strobe for the transmit data word |
| tx_wdata | input | 16 | Transmit data word, right-aligned |
| rx_rd | input | 1 | Read strobe that empties the receive buffer |
| rx_rdata | output | 16 | Receive buffer, right-aligned and zero-extended |
| rx_valid | output | 1 | Receive buffer holds an unread character |
| tx_req | output | 1 | Transmit DMA request pulse |
| rx_req | output | 1 | Receive DMA request pulse |
| tx_ovr | output | 1 | Sticky transmit overrun flag |
| rx_ovr | output | 1 | Sticky receive overrun flag |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong bit counter or a wrongly latched length shows up on the wire within the first character: the slave model collects too few or too many bits, and the scoreboard reports a word mismatch or an unexpected character. A transmit buffer that is not emptied correctly shows up as a missing or extra character and as a wrong count of tx_req pulses by the time chip select rises. Errors in the request logic appear one cycle after the copy event, as a pulse count that differs from the number of words moved. A prescaler fault shows up in the measured SCLK phase length during the first bit.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

    localparam int MAX_BITS = 16;
    localparam int MIN_BITS = 2;
    localparam int LEN_W    = $clog2(MAX_BITS + 1);

    typedef logic [MAX_BITS-1:0] word_t;
    typedef logic [LEN_W-1:0]    len_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    // A character as it enters the shift register: payload and its length.
    typedef struct packed {
        word_t data;
        len_t  len;
    } char_t;

    function automatic len_t fit_len(input len_t raw);
        if (raw < len_t'(MIN_BITS))
            return len_t'(MIN_BITS);
        else if (raw > len_t'(MAX_BITS))
            return len_t'(MAX_BITS);
        else
            return raw;
    endfunction

    // Places bit n-1 of a right-aligned word at the top of the shifter.
    function automatic word_t left_align(input word_t d, input len_t n);
        return word_t'(d << (MAX_BITS - int'(n)));
    endfunction

endpackage

// File: rtl/spi_tx_stage.sv
module spi_tx_stage
    import spi_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  wr,
    input  word_t wdata,
    input  len_t  len,
    input  logic  sh_idle,
    input  logic  sh_done,
    output logic  load,
    output char_t load_char,
    output logic  ovr
);

    logic  full_q;
    word_t hold_q;

    logic from_hold;
    logic direct;
    logic to_hold;
    logic drop;

    always_comb begin
        from_hold = sh_done & full_q;
        direct    = wr & en & ~full_q & (sh_idle | sh_done);
        to_hold   = wr & en & ~direct & (~full_q | from_hold);
        drop      = wr & en & full_q & ~from_hold;
        load      = from_hold | direct;
        load_char.data = from_hold ? hold_q : wdata;
        load_char.len  = len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            hold_q <= '0;
            ovr    <= 1'b0;
        end else begin
            if (!en) begin
                full_q <= 1'b0;
            end else if (to_hold) begin
                full_q <= 1'b1;
                hold_q <= wdata;
            end else if (from_hold) begin
                full_q <= 1'b0;
            end
            if (drop)
                ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_dma_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  char_t            load_char,
    input  logic [DIV_W-1:0] half,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output word_t            rx_word
);

    sh_state_e        state_q;
    word_t            tx_sr_q;
    word_t            rx_sr_q;
    len_t             bit_q;
    len_t             len_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] half_q;
    logic             sclk_q;
    logic             tick;

    always_comb begin
        busy    = (state_q == SH_RUN);
        tick    = busy && (div_q == half_q - 1'b1);
        done    = tick && sclk_q && (bit_q == len_q - 1'b1);
        sclk    = sclk_q;
        mosi    = busy ? tx_sr_q[MAX_BITS-1] : 1'b0;
        rx_word = rx_sr_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= SH_IDLE;
            tx_sr_q <= '0;
            rx_sr_q <= '0;
            bit_q   <= '0;
            len_q   <= len_t'(MIN_BITS);
            div_q   <= '0;
            half_q  <= DIV_W'(1);
            sclk_q  <= 1'b0;
        end else if (load) begin
            state_q <= SH_RUN;
            tx_sr_q <= left_align(load_char.data, load_char.len);
            rx_sr_q <= '0;
            bit_q   <= '0;
            len_q   <= load_char.len;
            div_q   <= '0;
            half_q  <= half;
            sclk_q  <= 1'b0;
        end else if (done) begin
            state_q <= SH_IDLE;
            div_q   <= '0;
            sclk_q  <= 1'b0;
        end else if (busy) begin
            if (tick) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q  <= 1'b1;
                    rx_sr_q <= {rx_sr_q[MAX_BITS-2:0], miso};
                end else begin
                    sclk_q  <= 1'b0;
                    tx_sr_q <= tx_sr_q << 1;
                    bit_q   <= bit_q + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_rx_stage.sv
module spi_rx_stage
    import spi_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  capture,
    input  word_t cap_word,
    input  logic  rd,
    output word_t rdata,
    output logic  valid,
    output logic  ovr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            valid <= 1'b0;
            ovr   <= 1'b0;
        end else if (capture) begin
            rdata <= cap_word;
            valid <= 1'b1;
            if (valid && !rd)
                ovr <= 1'b1;
        end else if (rd) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_dma_master.sv
module spi_dma_master
    import spi_dma_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_en,
    input  logic                dma_req_en,
    input  logic [LEN_W-1:0]    char_len,
    input  logic [DIV_W-1:0]    clk_half,
    input  logic                tx_wr,
    input  logic [MAX_BITS-1:0] tx_wdata,
    input  logic                rx_rd,
    output logic [MAX_BITS-1:0] rx_rdata,
    output logic                rx_valid,
    output logic                tx_req,
    output logic                rx_req,
    output logic                tx_ovr,
    output logic                rx_ovr,
    output logic                sclk,
    output logic                mosi,
    input  logic                miso,
    output logic                cs_n
);

    len_t             len_c;
    logic [DIV_W-1:0] half_c;
    logic             load;
    char_t            load_char;
    logic             sh_busy;
    logic             sh_done;
    word_t            sh_rx;
    logic             both_q;
    logic             first_req;

    always_comb begin
        len_c     = fit_len(char_len);
        half_c    = (clk_half == '0) ? DIV_W'(1) : clk_half;
        first_req = spi_en & dma_req_en & ~both_q;
        cs_n      = ~sh_busy;
    end

    spi_tx_stage u_tx (
        .clk       (clk),
        .rst       (rst),
        .en        (spi_en),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .len       (len_c),
        .sh_idle   (~sh_busy),
        .sh_done   (sh_done),
        .load      (load),
        .load_char (load_char),
        .ovr       (tx_ovr)
    );

    spi_shifter #(.DIV_W(DIV_W)) u_sh (
        .clk       (clk),
        .rst       (rst),
        .en        (spi_en),
        .load      (load),
        .load_char (load_char),
        .half      (half_c),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (sh_busy),
        .done      (sh_done),
        .rx_word   (sh_rx)
    );

    spi_rx_stage u_rx (
        .clk      (clk),
        .rst      (rst),
        .capture  (sh_done),
        .cap_word (sh_rx),
        .rd       (rx_rd),
        .rdata    (rx_rdata),
        .valid    (rx_valid),
        .ovr      (rx_ovr)
    );

    // Request pulses: one cycle after the copy event, gated by the enable.
    always_ff @(posedge clk) begin
        if (rst) begin
            both_q <= 1'b0;
            tx_req <= 1'b0;
            rx_req <= 1'b0;
        end else begin
            both_q <= spi_en & dma_req_en;
            tx_req <= dma_req_en & spi_en & (first_req | load);
            rx_req <= dma_req_en & sh_done;
        end
    end

endmodule

// File: rtl/spi_dma_master_chk.sv
module spi_dma_master_chk (
    input logic clk,
    input logic rst,
    input logic spi_en,
    input logic dma_req_en,
    input logic tx_req,
    input logic rx_req,
    input logic rx_valid,
    input logic tx_ovr,
    input logic rx_ovr,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);

    // R3: serial lines idle low while chip select is high
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && !mosi));

    // R6: both enables arriving together produce a transmit request
    p_first_req_r6: assert property (@(posedge clk) disable iff (rst)
        (spi_en && dma_req_en && !$past(spi_en && dma_req_en)) |=> tx_req);

    // R7: receive request lasts one cycle and coincides with valid data
    p_rx_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rx_req |=> !rx_req);

    p_rx_valid_r7: assert property (@(posedge clk) disable iff (rst)
        rx_req |-> rx_valid);

    // R8: no requests follow a cycle with request enable low
    p_no_req_r8: assert property (@(posedge clk) disable iff (rst)
        !dma_req_en |=> (!tx_req && !rx_req));

    // R10: transmit overrun is sticky
    p_tx_ovr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        tx_ovr |=> tx_ovr);

    // R11: receive overrun is sticky
    p_rx_ovr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        rx_ovr |=> rx_ovr);

    // R12: disabling the engine releases chip select on the next cycle
    p_disable_r12: assert property (@(posedge clk) disable iff (rst)
        !spi_en |=> cs_n);

endmodule

bind spi_dma_master spi_dma_master_chk u_chk (.*);

// File: tb/spi_dma_master_bench.sv
module spi_dma_master_bench;
    import spi_dma_pkg::*;

    localparam int DIVW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            spi_en = 1'b0;
    logic            dma_req_en = 1'b0;
    logic [LEN_W-1:0] char_len = 5'd8;
    logic [DIVW-1:0] clk_half = 8'd2;
    logic            tx_wr = 1'b0;
    logic [15:0]     tx_wdata = '0;
    logic            rx_rd = 1'b0;
    logic [15:0]     rx_rdata;
    logic            rx_valid, tx_req, rx_req, tx_ovr, rx_ovr;
    logic            sclk, mosi, cs_n;
    logic            miso;

    always #4 clk = ~clk;

    spi_dma_master #(.DIV_W(DIVW)) u_spi_dma_master (
        .clk(clk), .rst(rst), .spi_en(spi_en), .dma_req_en(dma_req_en),
        .char_len(char_len), .clk_half(clk_half), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_valid(rx_valid), .tx_req(tx_req), .rx_req(rx_req),
        .tx_ovr(tx_ovr), .rx_ovr(rx_ovr), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int eff_len = 8;
    int exp_q[$];
    int miso_q[$];
    int got_n = 0;

    int tx_req_n, rx_req_n, cs_rise_n, cs_fall_n;
    int hi_min, hi_max, lo_min, lo_max, hi_run, lo_run;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int mask(input int v, input int n);
        return v & ((1 << n) - 1);
    endfunction

    function automatic int fit(input int l);
        if (l < 2) return 2;
        if (l > 16) return 16;
        return l;
    endfunction

    task automatic clear_stats();
        tx_req_n = 0; rx_req_n = 0; cs_rise_n = 0; cs_fall_n = 0;
        hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
    endtask

    // Monitor of request pulses, chip select and SCLK phase lengths.
    initial begin
        logic pcs;
        pcs = 1'b1; hi_run = 0; lo_run = 0;
        clear_stats();
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (tx_req) tx_req_n++;
                if (rx_req) rx_req_n++;
                if (!pcs && cs_n) cs_rise_n++;
                if (pcs && !cs_n) cs_fall_n++;
                if (sclk) begin
                    hi_run++;
                    if (lo_run > 0) begin
                        if (lo_run < lo_min) lo_min = lo_run;
                        if (lo_run > lo_max) lo_max = lo_run;
                        lo_run = 0;
                    end
                end else begin
                    if (hi_run > 0) begin
                        if (hi_run < hi_min) hi_min = hi_run;
                        if (hi_run > hi_max) hi_max = hi_run;
                        hi_run = 0;
                    end
                    if (!cs_n) lo_run++; else lo_run = 0;
                end
                pcs = cs_n;
            end
        end
    end

    function automatic int pop_miso();
        if (miso_q.size() > 0) return miso_q.pop_front();
        return 0;
    endfunction

    // Slave model and scoreboard: collects MOSI, drives MISO, compares words.
    initial begin
        logic ps, pc;
        int nb, rxw, mw;
        miso = 1'b0; ps = 1'b0; pc = 1'b1; nb = 0; rxw = 0; mw = 0;
        forever begin
            @(sclk or cs_n);
            #1;
            if (pc && !cs_n) begin
                nb = 0; rxw = 0;
                mw = pop_miso();
                miso = mw[eff_len-1];
            end else if (!ps && sclk) begin
                rxw = (rxw << 1) | int'(mosi);
                nb++;
                if (nb == eff_len) begin
                    got_n++;
                    if (exp_q.size() == 0)
                        check_eq("R5", "unexpected character on MOSI", rxw, -1);
                    else
                        check_eq("R3", "MOSI word at slave", rxw, exp_q.pop_front());
                    nb = 0; rxw = 0;
                end
            end else if (ps && !sclk && !cs_n) begin
                if (nb == 0) begin
                    mw = pop_miso();
                    miso = mw[eff_len-1];
                end else begin
                    miso = mw[eff_len-1-nb];
                end
            end
            ps = sclk; pc = cs_n;
        end
    end

    task automatic wr_word(input int w);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_wdata = 16'(w);
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    // Driver: a word expected on the wire plus the slave's reply.
    task automatic send(input int mo, input int mi);
        exp_q.push_back(mask(mo, eff_len));
        miso_q.push_back(mi);
        wr_word(mo);
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        repeat (2) @(negedge clk);
        while (!cs_n && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic read_rx();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int g0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "cs_n", int'(cs_n), 1);
        check_eq("R1", "sclk/mosi", int'({sclk, mosi}), 0);
        check_eq("R1", "req pulses", int'({tx_req, rx_req}), 0);
        check_eq("R1", "valid/flags", int'({rx_valid, tx_ovr, rx_ovr}), 0);
        check_eq("R1", "rx_rdata", int'(rx_rdata), 0);

        // R6 initial request with no data written
        clear_stats();
        spi_en = 1'b1; dma_req_en = 1'b1;
        repeat (6) @(negedge clk);
        check_eq("R6", "initial tx_req count", tx_req_n, 1);
        check_eq("R6", "cs_n with no data", int'(cs_n), 1);

        // R3 R4 R5 R7 basic 8-bit character, phase length 2
        clear_stats();
        char_len = 5'd8; clk_half = 8'd2; eff_len = 8;
        send('h3C, 'hA5);
        wait_idle();
        check_eq("R7", "rx_rdata 8-bit", int'(rx_rdata), 'hA5);
        check_eq("R7", "rx_valid set", int'(rx_valid), 1);
        check_eq("R5", "tx_req count", tx_req_n, 1);
        check_eq("R7", "rx_req count", rx_req_n, 1);
        check_eq("R4", "sclk high min", hi_min, 2);
        check_eq("R4", "sclk high max", hi_max, 2);
        check_eq("R4", "sclk low min", lo_min, 2);
        check_eq("R4", "sclk low max", lo_max, 2);
        read_rx();
        @(negedge clk);
        check_eq("R7", "rx_valid cleared by read", int'(rx_valid), 0);

        // R2 R4 16-bit character, clk_half 0 acts as 1
        clear_stats();
        char_len = 5'd16; clk_half = 8'd0; eff_len = 16;
        send('hBEEF, 'h1234);
        wait_idle();
        check_eq("R2", "rx_rdata 16-bit", int'(rx_rdata), 'h1234);
        check_eq("R4", "sclk high with half 0", hi_max, 1);
        check_eq("R4", "sclk low with half 0", lo_max, 1);
        read_rx();

        // R2 R3 shortest length, upper bits of rx zero
        char_len = 5'd2; clk_half = 8'd3; eff_len = 2;
        send('hFFF2, 'hFFFD);
        wait_idle();
        check_eq("R3", "rx_rdata 2-bit zero-extended", int'(rx_rdata), 1);
        read_rx();

        // R2 clamp: char_len 0 moves two bits
        char_len = 5'd0; clk_half = 8'd1; eff_len = fit(0);
        g0 = got_n;
        send('h0003, 'h0002);
        wait_idle();
        check_eq("R2", "clamped rx_rdata", int'(rx_rdata), 2);
        check_eq("R2", "clamped char count", got_n - g0, 1);
        read_rx();

        // R9 R11 back-to-back through the buffer, second unread overruns
        clear_stats();
        char_len = 5'd8; clk_half = 8'd2; eff_len = 8;
        send('h81, 'h5A);
        send('h7E, 'hC3);
        wait_idle();
        check_eq("R9", "cs_n rises once for two chars", cs_rise_n, 1);
        check_eq("R9", "cs_n falls once for two chars", cs_fall_n, 1);
        check_eq("R5", "tx_req back-to-back", tx_req_n, 2);
        check_eq("R7", "rx_req back-to-back", rx_req_n, 2);
        check_eq("R11", "rx_ovr set", int'(rx_ovr), 1);
        check_eq("R11", "newest char kept", int'(rx_rdata), 'hC3);
        check_eq("R10", "tx_ovr still clear", int'(tx_ovr), 0);
        read_rx();

        // R10 third write against a full buffer is dropped
        clear_stats();
        g0 = got_n;
        send('h11, 'h22);
        send('h33, 'h44);
        wr_word('h99);
        wait_idle();
        check_eq("R10", "tx_ovr set", int'(tx_ovr), 1);
        check_eq("R10", "chars on wire", got_n - g0, 2);
        check_eq("R5", "tx_req with drop", tx_req_n, 2);
        check_eq("R11", "rx_ovr sticky", int'(rx_ovr), 1);
        read_rx();

        // R8 requests off, transfer still runs
        clear_stats();
        @(negedge clk);
        dma_req_en = 1'b0;
        send('hA7, 'h6B);
        wait_idle();
        check_eq("R8", "tx_req while disabled", tx_req_n, 0);
        check_eq("R8", "rx_req while disabled", rx_req_n, 0);
        check_eq("R8", "data still moved", int'(rx_rdata), 'h6B);
        read_rx();
        clear_stats();
        dma_req_en = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R6", "re-arm tx_req", tx_req_n, 1);

        // R12 abort mid-character, then writes ignored while disabled
        char_len = 5'd16; clk_half = 8'd4; eff_len = 16;
        g0 = got_n;
        miso_q.push_back('h0F0F);
        wr_word('hFFFF);
        repeat (10) @(negedge clk);
        check_eq("R12", "cs_n low before abort", int'(cs_n), 0);
        spi_en = 1'b0;
        @(negedge clk);
        check_eq("R12", "cs_n after disable", int'(cs_n), 1);
        clear_stats();
        wr_word('h5555);
        repeat (40) @(negedge clk);
        check_eq("R12", "cs_n falls while disabled", cs_fall_n, 0);
        check_eq("R12", "chars completed", got_n - g0, 0);
        check_eq("R12", "pending expected chars", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule